// File: doc/BRIEF.md
# OTP Programming Unlock Sequencer

This block sits between a one-time-programmable memory controller's register file and its command engine, and guards the path that burns fuses. The register file hands it a command code, a data word written by the CPU, and a start strobe. The block does not open programming for a single enable bit. Software must instead submit four specific data values in a fixed order. Each value goes in as its own started program-enable command. Once the fourth value has been accepted, the block raises a permission signal for the command engine and a program-ok status.

Each step completes through a command-done flag. Software waits for this flag and then clears start. A program-disable command withdraws permission. That command completes with program-ok shown for as long as start stays high, so software polling either status bit finds the command finished. A wrong value at any step sends the matcher back to the first step. Command-done is still reported for a wrong value, so software polling for completion never stalls.

The block carries no data stream. It has no valid/ready handshake and applies no back-pressure. All pins are plain control and status levels, sampled on every clock.

Top module: `otp_unlock_seq`

## Requirements
- R1: While reset is asserted and after it is released, cmd_done, prog_ok and prog_en are low. The matcher waits at its first step: the full four-value pattern given right after reset unlocks, and the last three values alone do not.
- R2: The command field is 6 bits wide. Program-enable is code 0x02 and program-disable is code 0x03. Any other code (for example 0x00 or 0x08) with a start edge raises no cmd_done, leaves the matcher position unchanged, and leaves permission unchanged.
- R3: Under code 0x02, the 32-bit data words 0x0000000F, 0x00000004, 0x00000008 and 0x0000000D, accepted in that order, unlock the block. prog_en and prog_ok go high at the clock edge that accepts the fourth value.
- R4: A step is taken only on a low-to-high transition of start. Holding start high for several cycles, even while the data word changes, takes no further step.
- R5: A start edge carrying code 0x02 or 0x03 sets cmd_done at that clock edge. cmd_done stays high while start is high and clears at the first clock edge that sees start low.
- R6: A data word under code 0x02 that differs from the value expected at the current step returns the matcher to the first step. That word is not itself taken as a first-step value. prog_ok stays low and cmd_done is still set.
- R7: A start edge with code 0x02 while already unlocked leaves prog_en and prog_ok high.
- R8: A start edge with code 0x03 clears prog_en and returns the matcher to the first step. prog_ok reads high together with cmd_done until start goes low, and then reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 6 | Command field from the register file |
| wr_data | input | 32 | CPU write-data word |
| start | input | 1 | Start bit; a rising level submits the command |
| cmd_done | output | 1 | Command completion status |
| prog_ok | output | 1 | Programming permitted / disable acknowledged |
| prog_en | output | 1 | Programming permission to the command engine |

## Verification
The hardest case to reach is a start level held high across several cycles while the data word changes to the next expected value. If this is mistaken for a new step, the effect shows only several commands later, as a failed unlock. The stimulus holds the first value with start high, switches the data word to the second value, drops start, and then submits the remaining values. A correct design unlocks from this sequence; a design that treats levels as steps does not. A mismatching value partway through the pattern, followed by a restart, and a program command inserted between steps show that the matcher position moves only as required.

// File: rtl/otp_unlock_pkg.sv
package otp_unlock_pkg;
  localparam int CMD_W  = 6;
  localparam int DATA_W = 32;
  localparam int STEPS  = 4;

  localparam logic [CMD_W-1:0] CMD_PROG_EN  = 6'h02;
  localparam logic [CMD_W-1:0] CMD_PROG_DIS = 6'h03;

  // Expected data word for each step of the unlock pattern (order matters).
  function automatic logic [31:0] unlock_word(input int idx);
    case (idx)
      0:       return 32'h0000_000F;
      1:       return 32'h0000_0004;
      2:       return 32'h0000_0008;
      default: return 32'h0000_000D;
    endcase
  endfunction
endpackage

// File: rtl/otp_start_edge.sv
module otp_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic rise
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start;
  end

  assign rise = start & ~start_q;

  // R4
  start_single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/otp_done_tracker.sv
module otp_done_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic strobe,
  input  logic is_ctl,
  input  logic is_dis,
  output logic cmd_done,
  output logic dis_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n || !start) begin
      cmd_done <= 1'b0;
      dis_ack  <= 1'b0;
    end else if (strobe && is_ctl) begin
      cmd_done <= 1'b1;
      dis_ack  <= is_dis;
    end
  end

  // R5
  done_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !cmd_done);

  // R8
  ack_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_ack |-> cmd_done);
endmodule

// File: rtl/otp_unlock_matcher.sv
module otp_unlock_matcher
  import otp_unlock_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NSTEP = STEPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          is_en,
  input  logic          is_dis,
  input  logic [DW-1:0] data,
  output logic          unlocked
);
  localparam int SW = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

  logic [SW-1:0] step_q;
  logic [DW-1:0] expect_w;
  logic          hit;

  assign expect_w = DW'(unlock_word(int'(step_q)));
  assign hit      = (data == expect_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= '0;
      unlocked <= 1'b0;
    end else if (strobe) begin
      if (is_dis) begin
        step_q   <= '0;
        unlocked <= 1'b0;
      end else if (is_en && !unlocked) begin
        if (!hit) begin
          step_q <= '0;
        end else if (step_q == LAST) begin
          step_q   <= '0;
          unlocked <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  // R4
  hold_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(step_q) && $stable(unlocked)));

  // R3
  unlock_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> ($past(step_q) == LAST && $past(is_en)));

  // R8
  disable_revokes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && is_dis) |=> (!unlocked && step_q == '0));
endmodule

// File: rtl/otp_unlock_seq.sv
module otp_unlock_seq
  import otp_unlock_pkg::*;
#(
  parameter int CW = CMD_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cmd_code,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  output logic          cmd_done,
  output logic          prog_ok,
  output logic          prog_en
);
  logic rise;
  logic is_en;
  logic is_dis;
  logic dis_ack;
  logic unlocked;

  assign is_en  = (cmd_code == CW'(CMD_PROG_EN));
  assign is_dis = (cmd_code == CW'(CMD_PROG_DIS));

  otp_start_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .rise  (rise)
  );

  otp_done_tracker u_done (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .strobe   (rise),
    .is_ctl   (is_en | is_dis),
    .is_dis   (is_dis),
    .cmd_done (cmd_done),
    .dis_ack  (dis_ack)
  );

  otp_unlock_matcher #(.DW(DW), .NSTEP(STEPS)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (rise),
    .is_en    (is_en),
    .is_dis   (is_dis),
    .data     (wr_data),
    .unlocked (unlocked)
  );

  assign prog_en = unlocked;
  assign prog_ok = unlocked | dis_ack;

  // R2
  other_cmd_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !is_en && !is_dis) |=> !$rose(cmd_done));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!cmd_done && !prog_en && !prog_ok));
endmodule

// File: tb/tb_otp_unlock_seq.sv
module tb_otp_unlock_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cmd_code = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic        cmd_done, prog_ok, prog_en;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  otp_unlock_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .wr_data(wr_data),
    .start(start), .cmd_done(cmd_done), .prog_ok(prog_ok), .prog_en(prog_en)
  );

  // {cmd, data, done while high, ok while high, en}
  localparam int NV = 17;
  localparam logic [40:0] VEC [NV] = '{
    {6'h02, 32'h0000000F, 3'b100},  // R3 step 1
    {6'h02, 32'h00000004, 3'b100},  // R3 step 2
    {6'h02, 32'h00000007, 3'b100},  // R6 wrong value
    {6'h02, 32'h00000004, 3'b100},  // R6 back at step 1
    {6'h02, 32'h0000000F, 3'b100},
    {6'h02, 32'h00000004, 3'b100},
    {6'h02, 32'h00000008, 3'b100},
    {6'h02, 32'h0000000D, 3'b111},  // R3 unlock
    {6'h02, 32'h00000005, 3'b111},  // R7 stays unlocked
    {6'h00, 32'h0000000F, 3'b011},  // R2 read code ignored
    {6'h03, 32'h00000000, 3'b110},  // R8 disable
    {6'h02, 32'h0000000F, 3'b100},
    {6'h08, 32'h0000000D, 3'b000},  // R2 program code does not move matcher
    {6'h02, 32'h00000004, 3'b100},
    {6'h02, 32'h00000008, 3'b100},
    {6'h02, 32'h0000000D, 3'b111},
    {6'h03, 32'h00000000, 3'b110}   // R8
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {done,ok,en} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Submit one command; check while start high and after it drops.
  task automatic step(input logic [5:0] c, input logic [31:0] d,
                      input logic [2:0] exp_hi, input string req);
    @(negedge clk);
    cmd_code = c; wr_data = d; start = 1'b1;
    @(negedge clk);
    chk(req, {cmd_done, prog_ok, prog_en}, exp_hi);
    start = 1'b0;
    @(negedge clk);
    chk({req, " R5 after start low"}, {cmd_done, prog_ok, prog_en},
        {1'b0, exp_hi[0], exp_hi[0]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", {cmd_done, prog_ok, prog_en}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {cmd_done, prog_ok, prog_en}, 3'b000);
  endtask

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++)
      step(VEC[i][40:35], VEC[i][34:3], VEC[i][2:0], $sformatf("R3/R6 vector %0d", i));

    // R1: reset mid-unlock; last three values alone must not unlock.
    step(6'h02, 32'hF, 3'b100, "R3");
    step(6'h02, 32'h4, 3'b100, "R3");
    step(6'h02, 32'h8, 3'b100, "R3");
    do_reset();
    step(6'h02, 32'h4, 3'b100, "R1 pointer at step 0");
    step(6'h02, 32'h8, 3'b100, "R1 pointer at step 0");
    step(6'h02, 32'hD, 3'b100, "R1 no unlock without first value");

    // R6: upper bits nonzero on last value is a mismatch.
    step(6'h02, 32'hF, 3'b100, "R6");
    step(6'h02, 32'h4, 3'b100, "R6");
    step(6'h02, 32'h8, 3'b100, "R6");
    step(6'h02, 32'h1000000D, 3'b100, "R6 wide mismatch");

    // R4: held start with changing data takes only one step.
    @(negedge clk);
    cmd_code = 6'h02; wr_data = 32'hF; start = 1'b1;
    @(negedge clk);
    chk("R5 done on edge", {cmd_done, prog_ok, prog_en}, 3'b100);
    wr_data = 32'h4;
    repeat (4) @(negedge clk);
    chk("R4 held start, done stays", {cmd_done, prog_ok, prog_en}, 3'b100);
    start = 1'b0;
    @(negedge clk);
    step(6'h02, 32'h4, 3'b100, "R4");
    step(6'h02, 32'h8, 3'b100, "R4");
    step(6'h02, 32'hD, 3'b111, "R4 unlock after held start");
    step(6'h03, 32'h0, 3'b110, "R8");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule